// File: doc/BRIEF.md
# USB Root Port Ownership Router

This block decides, port by port, whether the high-speed host controller or the legacy companion controller drives each root port. It tracks ownership in a one-bit register per port and gives each controller its own view of every port. That view has a connect status and a sticky connect-change flag. The speed controller's software sets a level flag when it has configured the controller. Per-port release requests hand individual ports down to the companion when the attached device is not high speed. The block takes in the physical attach status and the detected device speed. Line-state detection, protocol engines, registers and power switching sit outside it.

A handover always shows up as a synthetic disconnect on the side that loses the port and a connect on the side that gains it. Both appear at the same clock edge as the owner select changes. A device is therefore never visible to both controllers at once.

Top module: `usb_port_router`

## Requirements
- R1: During reset and after it, every port is companion-owned (`comp_own_o` bit = 1). All connect-status and connect-change outputs are 0.
- R2: While `hs_cfg_i` is 0 at a clock edge, every port is companion-owned after that edge.
- R3: At the first edge where `hs_cfg_i` is 1 after being 0, every port becomes owned by the high-speed controller (`comp_own_o` bit = 0). This holds whether or not a device is attached.
- R4: With `hs_cfg_i` held at 1, a port owned by the high-speed controller moves to the companion at the next edge. This happens when its `rel_req_i` bit is 1, its `attach_i` bit is 1 and its `dev_hs_i` bit is 0.
- R5: A release request is ignored when nothing is attached, when the device is high speed, or when the port is already companion-owned. The owner select for that port does not change.
- R6: With `hs_cfg_i` held at 1, a companion-owned port whose `attach_i` bit is 0 returns to the high-speed controller at the next edge.
- R7: One edge after the inputs, `hs_conn_o` equals attach AND high-speed-owned, and `cp_conn_o` equals attach AND companion-owned. The two are never both 1 for a port.
- R8: A connect-change bit is set at the edge where that controller's connect status for the port changes. This is the same edge at which the owner select changes.
- R9: Connect-change bits stay set until a 1 on the matching clear bit (`hs_chg_clr_i` or `cp_chg_clr_i`). If a new change and a clear arrive in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_cfg_i | input | 1 | High-speed controller configured by software (level) |
| rel_req_i | input | NUM_PORTS | Per-port release-to-companion request |
| dev_hs_i | input | NUM_PORTS | Attached device detected as high speed |
| attach_i | input | NUM_PORTS | Physical device attached |
| hs_chg_clr_i | input | NUM_PORTS | Clear pulse for high-speed connect-change bits |
| cp_chg_clr_i | input | NUM_PORTS | Clear pulse for companion connect-change bits |
| comp_own_o | output | NUM_PORTS | Owner select, 1 = companion, 0 = high-speed |
| hs_conn_o | output | NUM_PORTS | Connect status seen by the high-speed controller |
| hs_chg_o | output | NUM_PORTS | Sticky connect-change for the high-speed controller |
| cp_conn_o | output | NUM_PORTS | Connect status seen by the companion |
| cp_chg_o | output | NUM_PORTS | Sticky connect-change for the companion |

## Verification
Every output is registered, so each result is due exactly one rising edge after the input values present at that edge. This applies to owner select, both connect views and both change flags. The bench drives inputs away from the edge and steps its reference model once per edge from those inputs. It compares every output bit a quarter period after the edge, so a result that arrives a cycle early or late is reported. Directed phases cover configure, release, ignored releases, return on detach, simultaneous set and clear, and de-configure. A stretch of random stimulus follows.

// File: rtl/usb_route_pkg.sv
package usb_route_pkg;
  typedef enum logic {
    OWN_HS   = 1'b0,
    OWN_COMP = 1'b1
  } owner_e;
endpackage

// File: rtl/port_owner_cell.sv
module port_owner_cell
  import usb_route_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_i,
  input  logic cfg_q_i,
  input  logic rel_i,
  input  logic att_i,
  input  logic hs_dev_i,
  output logic own_d_o,
  output logic own_o
);
  owner_e own_q, own_d;

  // next-state
  always_comb begin
    own_d = own_q;
    if (!cfg_i)
      own_d = OWN_COMP;
    else if (!cfg_q_i)
      own_d = OWN_HS;
    else if ((own_q == OWN_COMP) && !att_i)
      own_d = OWN_HS;
    else if ((own_q == OWN_HS) && rel_i && att_i && !hs_dev_i)
      own_d = OWN_COMP;
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= OWN_COMP;
    else        own_q <= own_d;
  end

  assign own_d_o = (own_d == OWN_COMP);
  assign own_o   = (own_q == OWN_COMP);

  AST_UNCFG_COMP: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i |=> own_o); // R2
  AST_CFG_RISE_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i && !cfg_q_i) |=> !own_o); // R3
  AST_REL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i && cfg_q_i && !own_o && rel_i && (!att_i || hs_dev_i)) |=> !own_o); // R5
  AST_RETURN_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i && cfg_q_i && own_o && !att_i) |=> !own_o); // R6
endmodule

// File: rtl/conn_view_cell.sv
module conn_view_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic att_i,
  input  logic mine_i,
  input  logic clr_i,
  output logic conn_o,
  output logic chg_o
);
  logic conn_q, conn_d, chg_q, chg_d, conn_en;

  // next-state
  always_comb begin
    conn_d  = att_i & mine_i;
    conn_en = (conn_d != conn_q);
    chg_d   = (chg_q & ~clr_i) | conn_en;
  end

  // registers, connect status loaded only when it moves
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      if (conn_en) conn_q <= conn_d;
      chg_q <= chg_d;
    end
  end

  assign conn_o = conn_q;
  assign chg_o  = chg_q;

  AST_CHG_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(conn_q) |-> chg_q); // R8
  AST_CHG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_q && !clr_i) |=> chg_q); // R9
endmodule

// File: rtl/usb_port_router.sv
module usb_port_router #(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hs_cfg_i,
  input  logic [NUM_PORTS-1:0] rel_req_i,
  input  logic [NUM_PORTS-1:0] dev_hs_i,
  input  logic [NUM_PORTS-1:0] attach_i,
  input  logic [NUM_PORTS-1:0] hs_chg_clr_i,
  input  logic [NUM_PORTS-1:0] cp_chg_clr_i,
  output logic [NUM_PORTS-1:0] comp_own_o,
  output logic [NUM_PORTS-1:0] hs_conn_o,
  output logic [NUM_PORTS-1:0] hs_chg_o,
  output logic [NUM_PORTS-1:0] cp_conn_o,
  output logic [NUM_PORTS-1:0] cp_chg_o
);
  localparam int LastPort = NUM_PORTS - 1;

  logic cfg_q;
  logic [LastPort:0] own_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= 1'b0;
    else        cfg_q <= hs_cfg_i;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    port_owner_cell u_own (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_i    (hs_cfg_i),
      .cfg_q_i  (cfg_q),
      .rel_i    (rel_req_i[p]),
      .att_i    (attach_i[p]),
      .hs_dev_i (dev_hs_i[p]),
      .own_d_o  (own_d[p]),
      .own_o    (comp_own_o[p])
    );
    conn_view_cell u_hs_view (
      .clk    (clk),
      .rst_n  (rst_n),
      .att_i  (attach_i[p]),
      .mine_i (~own_d[p]),
      .clr_i  (hs_chg_clr_i[p]),
      .conn_o (hs_conn_o[p]),
      .chg_o  (hs_chg_o[p])
    );
    conn_view_cell u_cp_view (
      .clk    (clk),
      .rst_n  (rst_n),
      .att_i  (attach_i[p]),
      .mine_i (own_d[p]),
      .clr_i  (cp_chg_clr_i[p]),
      .conn_o (cp_conn_o[p]),
      .chg_o  (cp_chg_o[p])
    );
  end

  AST_NO_DUAL_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_conn_o & cp_conn_o) == '0); // R7
  AST_CONN_OWNER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((hs_conn_o & comp_own_o) | (cp_conn_o & ~comp_own_o)) == '0); // R7
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_cfg_i && cfg_q && ((~comp_own_o & rel_req_i & attach_i & ~dev_hs_i) != '0))
      |=> (comp_own_o != '0)); // R4
  AST_RESET_VAL: assert property (@(posedge clk)
    !rst_n |=> (comp_own_o == '1) || !rst_n); // R1
endmodule

// File: tb/test_usb_port_router.sv
`timescale 1ns/1ps
module test_usb_port_router;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_cfg = 1'b0;
  logic [NP-1:0] rel = '0, hsdev = '0, att = '0, hclr = '0, cclr = '0;
  logic [NP-1:0] own, hconn, hchg, cconn, cchg;

  int checks = 0;
  int errors = 0;

  // behavioural model state
  logic [NP-1:0] m_own = '1, m_hv = '0, m_cv = '0, m_hc = '0, m_cc = '0;
  logic m_cfgq = 1'b0;

  always #10 clk = ~clk;

  usb_port_router #(.NUM_PORTS(NP)) i_usb_port_router (
    .clk(clk), .rst_n(rst_n), .hs_cfg_i(hs_cfg), .rel_req_i(rel),
    .dev_hs_i(hsdev), .attach_i(att), .hs_chg_clr_i(hclr), .cp_chg_clr_i(cclr),
    .comp_own_o(own), .hs_conn_o(hconn), .hs_chg_o(hchg),
    .cp_conn_o(cconn), .cp_chg_o(cchg)
  );

  task automatic chk(input string tag, input string what,
                     input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "owner",   own,   m_own);
    chk(tag, "hs_conn", hconn, m_hv);
    chk(tag, "hs_chg",  hchg,  m_hc);
    chk(tag, "cp_conn", cconn, m_cv);
    chk(tag, "cp_chg",  cchg,  m_cc);
  endtask

  // advance one clock: model steps from the inputs seen at the edge
  task automatic cyc(input string tag);
    logic [NP-1:0] n_own, n_hv, n_cv;
    for (int p = 0; p < NP; p++) begin
      if (!hs_cfg)                         n_own[p] = 1'b1;
      else if (!m_cfgq)                    n_own[p] = 1'b0;
      else if (m_own[p] && !att[p])        n_own[p] = 1'b0;
      else if (!m_own[p] && rel[p] && att[p] && !hsdev[p]) n_own[p] = 1'b1;
      else                                 n_own[p] = m_own[p];
      n_hv[p] = att[p] && !n_own[p];
      n_cv[p] = att[p] && n_own[p];
    end
    m_hc   = (m_hc & ~hclr) | (n_hv ^ m_hv);
    m_cc   = (m_cc & ~cclr) | (n_cv ^ m_cv);
    m_own  = n_own;
    m_hv   = n_hv;
    m_cv   = n_cv;
    m_cfgq = hs_cfg;
    @(posedge clk);
    #5;
    chk_all(tag);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #5;
    chk_all("R1 reset");
    rst_n = 1'b1;
    cyc("R1 after reset");

    // devices attach while unconfigured: companion sees them
    att = 4'b1011; hsdev = 4'b0010;
    cyc("R2 unconfigured attach");
    cyc("R2 hold");
    cclr = '1; cyc("R9 clear companion changes"); cclr = '0;

    // configure: all ports to high-speed controller
    hs_cfg = 1'b1;
    cyc("R3 configure");
    hclr = '1; cclr = '1; cyc("R9 clear all"); hclr = '0; cclr = '0;

    // release requests: p0 full-speed attached -> released; p1 high speed; p2 empty
    rel = 4'b0111;
    cyc("R4 release p0, R5 ignore p1 p2");
    cyc("R5 already companion p0");
    rel = '0;
    cyc("R8 steady");

    // detach p0: returns to high-speed controller
    att[0] = 1'b0;
    cyc("R6 return on detach");
    // new event and clear in same cycle on p3 change
    hclr = '1; att[3] = 1'b0;
    cyc("R9 set wins over clear");
    hclr = '0;
    cclr = '1; cyc("R9 clear"); cclr = '0;

    // empty port released -> ignored
    rel = 4'b0100; cyc("R5 empty port"); rel = '0;

    // deconfigure
    hs_cfg = 1'b0;
    att = 4'b1111;
    cyc("R2 deconfigure");
    cyc("R7 views");

    // random stretch
    for (int i = 0; i < 400; i++) begin
      att   = NP'($urandom);
      hsdev = NP'($urandom);
      rel   = NP'($urandom);
      hclr  = NP'($urandom);
      cclr  = NP'($urandom);
      if (($urandom % 16) == 0) hs_cfg = ~hs_cfg;
      else if (i == 0) hs_cfg = 1'b1;
      cyc("R7 R8 R9 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule